// File: doc/BRIEF.md
# Two-Cycle Barrett CRC-32 / CRC-32C Step Unit

This unit advances a 32-bit reflected CRC state by 8, 16 or 32 bit-times in one operation. It does the same job as a bit-serial LFSR stepped that many times with no new data shifted in. The caller applies a start strobe together with the state, a width code and a polynomial select. The unit returns the advanced state two cycles later. Two generator polynomials are built in: the common CRC-32 (normal form 0x04C11DB7) and the Castagnoli CRC-32C (normal form 0x1EDC6F41). Message framing, the initial value and the final inversion are the caller's job. The usual pattern is to XOR a message chunk into the state and then issue one operation of the matching width.

The state is treated as a bit-reflected polynomial a(x), and the unit forms a(x)·x^n mod (x^32 + P(x)) by Barrett reduction. In the first cycle, a carry-less product of the n bits that overflow past x^32 with the precomputed constant floor(x^64 / (x^32+P)) gives the reduction quotient. In the second cycle, a carry-less product of that quotient with P gives the folded remainder. This remainder is XORed with the state shifted right by n. One 32×32 carry-less multiplier serves both cycles. The Barrett constants are derived from the polynomial parameters at elaboration.

A new operation can be accepted every second cycle. A start in the cycle right after an accepted one is dropped. The result register keeps its value until the next result is written.

Top module: `crc_brt_unit`

## Requirements
- R1: With poly_sel_i = 0, result_o equals n iterations of s = (s >> 1) ^ (32'hEDB88320 & {32{s[0]}}) starting from s = state_i.
- R2: With poly_sel_i = 1, result_o equals the same loop with the reflected constant 32'h82F63B78.
- R3: width_i selects n: 2'b00 gives 8, 2'b01 gives 16, 2'b10 and 2'b11 both give 32.
- R4: A start is accepted when start_i is high in a cycle where no operation is in progress. valid_o is then high for exactly one cycle, two cycles after the start cycle.
- R5: A start_i in the cycle following an accepted start is ignored. It produces no valid_o pulse and does not change the pending result.
- R6: result_o holds its value in every cycle in which valid_o is low.
- R7: While rst is high and in the first cycle after it, valid_o is 0 and result_o is 0.
- R8: A state of all zeros yields zero for every width and polynomial. A state of all ones yields the loop value of R1/R2.
- R9: Holding start_i high continuously gives accepted operations on every second cycle, with a result pulse for each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a new CRC step |
| state_i | input | 32 | Reflected CRC state to advance |
| width_i | input | 2 | Step size code (R3) |
| poly_sel_i | input | 1 | 0: CRC-32, 1: CRC-32C |
| result_o | output | 32 | Advanced CRC state, registered and held |
| valid_o | output | 1 | One-cycle pulse marking a new result_o |

## Verification
The bench compares every result against a bit-serial model for all six combinations of width and polynomial, using random states. The all-zero and all-ones states are included, because a wrong reflection or a wrong Barrett constant usually survives zero but not ones. The unused width code 2'b11 is exercised, and a decoder that treated it as byte or half would give a shorter step. A start issued in the busy cycle checks that the multiplier operands are not overwritten mid-operation, which would corrupt the pending result or emit a stray pulse. A continuously held start checks that the unit neither stalls nor accepts on every cycle.

// File: rtl/crc_brt_pkg.sv
package crc_brt_pkg;

  localparam int CRC_W = 32;

  // Bit-order reversal of a CRC-width word.
  function automatic logic [CRC_W-1:0] reflect(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  // Quotient of x^(2W) divided by (x^W + p), leading x^W term removed.
  function automatic logic [CRC_W-1:0] barrett_const(input logic [CRC_W-1:0] p);
    logic [2*CRC_W:0] rem;
    logic [CRC_W:0]   quo;
    logic [CRC_W:0]   gen;
    gen = {1'b1, p};
    rem = '0;
    quo = '0;
    rem[2*CRC_W] = 1'b1;
    for (int i = CRC_W; i >= 0; i--) begin
      if (rem[CRC_W+i]) begin
        quo[i] = 1'b1;
        rem = rem ^ ({{CRC_W{1'b0}}, gen} << i);
      end
    end
    return quo[CRC_W-1:0];
  endfunction

endpackage

// File: rtl/crc_brt_clmul.sv
// Carry-less multiplier: partial products combined in a binary XOR tree.
module crc_brt_clmul #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-2:0] prod_o
);
  localparam int PW = 2*W-1;

  // Heap-ordered tree: leaves W..2W-1, root 1.
  logic [PW-1:0] node [1:2*W-1];

  for (genvar i = 0; i < W; i++) begin : g_pp
    assign node[W+i] = b_i[i] ? ({{(W-1){1'b0}}, a_i} << i) : '0;
  end

  for (genvar k = 1; k < W; k++) begin : g_tree
    assign node[k] = node[2*k] ^ node[2*k+1];
  end

  assign prod_o = node[1];
endmodule

// File: rtl/crc_brt_operand.sv
// Splits the reflected state into the bits that overflow past x^W
// (head, returned in reflected order) and the part that shifts in place (tail).
module crc_brt_operand
  import crc_brt_pkg::*;
(
  input  logic [CRC_W-1:0] state_i,
  input  logic [1:0]       width_i,
  output logic [CRC_W-1:0] head_o,
  output logic [CRC_W-1:0] tail_o
);
  localparam int BYTE_W = CRC_W / 4;
  localparam int HALF_W = CRC_W / 2;

  logic [CRC_W-1:0] lifted;

  always_comb begin
    unique case (width_i)
      2'b00: begin
        lifted = {state_i[BYTE_W-1:0], {(CRC_W-BYTE_W){1'b0}}};
        tail_o = state_i >> BYTE_W;
      end
      2'b01: begin
        lifted = {state_i[HALF_W-1:0], {(CRC_W-HALF_W){1'b0}}};
        tail_o = state_i >> HALF_W;
      end
      default: begin
        lifted = state_i;
        tail_o = '0;
      end
    endcase
  end

  assign head_o = reflect(lifted);
endmodule

// File: rtl/crc_brt_ctrl.sv
// Two-phase sequencer: accept, then fold and write the result.
module crc_brt_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic valid_o
);
  logic busy_q;
  logic valid_q;

  assign accept_o = start_i & ~busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      busy_q  <= accept_o;
      valid_q <= busy_q;
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/crc_brt_unit.sv
module crc_brt_unit
  import crc_brt_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY_STD  = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] POLY_CAST = 32'h1EDC6F41
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CRC_W-1:0] state_i,
  input  logic [1:0]       width_i,
  input  logic             poly_sel_i,
  output logic [CRC_W-1:0] result_o,
  output logic             valid_o
);
  localparam logic [CRC_W-1:0] MU_STD  = barrett_const(POLY_STD);
  localparam logic [CRC_W-1:0] MU_CAST = barrett_const(POLY_CAST);
  localparam int PW = 2*CRC_W-1;

  logic             accept;
  logic             busy;
  logic [CRC_W-1:0] head;
  logic [CRC_W-1:0] tail;
  logic [CRC_W-1:0] mul_a;
  logic [CRC_W-1:0] mul_b;
  logic [PW-1:0]    prod;
  logic [CRC_W-1:0] quot;

  logic [CRC_W-1:0] quot_q;
  logic [CRC_W-1:0] tail_q;
  logic             psel_q;
  logic [CRC_W-1:0] result_q;

  crc_brt_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .valid_o  (valid_o)
  );

  crc_brt_operand i_operand (
    .state_i (state_i),
    .width_i (width_i),
    .head_o  (head),
    .tail_o  (tail)
  );

  // One multiplier, two uses: quotient estimate, then fold by P.
  always_comb begin
    if (busy) begin
      mul_a = quot_q;
      mul_b = psel_q ? POLY_CAST : POLY_STD;
    end else begin
      mul_a = head;
      mul_b = poly_sel_i ? MU_CAST : MU_STD;
    end
  end

  crc_brt_clmul #(.W(CRC_W)) i_clmul (
    .a_i    (mul_a),
    .b_i    (mul_b),
    .prod_o (prod)
  );

  // Full constant carries an implicit x^W term: quotient = head ^ upper product.
  assign quot = head ^ {1'b0, prod[PW-1:CRC_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      quot_q   <= '0;
      tail_q   <= '0;
      psel_q   <= 1'b0;
      result_q <= '0;
    end else begin
      if (accept) begin
        quot_q <= quot;
        tail_q <= tail;
        psel_q <= poly_sel_i;
      end
      if (busy) begin
        result_q <= tail_q ^ reflect(prod[CRC_W-1:0]);
      end
    end
  end

  assign result_o = result_q;
endmodule

// File: rtl/crc_brt_checker.sv
module crc_brt_checker (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic        busy_i,
  input logic        valid_o,
  input logic [31:0] result_o
);
  a_r7_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && result_o == 32'h0));

  a_r4_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_i) |=> busy_i);

  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_i) |-> ##2 valid_o);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r5_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> !busy_i);

  a_r9_valid_after_busy: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(busy_i));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(result_o));
endmodule

bind crc_brt_unit crc_brt_checker i_crc_brt_checker (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .busy_i   (busy),
  .valid_o  (valid_o),
  .result_o (result_o)
);

// File: tb/test_crc_brt_unit.sv
module test_crc_brt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] state_i = '0;
  logic [1:0]  width_i = '0;
  logic        poly_sel_i = 1'b0;
  logic [31:0] result_o;
  logic        valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  crc_brt_unit i_crc_brt_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .state_i(state_i),
    .width_i(width_i), .poly_sel_i(poly_sel_i),
    .result_o(result_o), .valid_o(valid_o)
  );

  function automatic logic [31:0] ref_crc(input logic [31:0] s, input logic [1:0] w,
                                          input logic p);
    logic [31:0] rp;
    int nb;
    rp = p ? 32'h82F63B78 : 32'hEDB88320;
    nb = (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : 32;
    for (int i = 0; i < nb; i++) s = (s >> 1) ^ (rp & {32{s[0]}});
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One operation; checks latency (R4) and value.
  task automatic run_one(input logic [31:0] s, input logic [1:0] w, input logic p,
                         input string tag);
    @(negedge clk);
    start_i = 1'b1; state_i = s; width_i = w; poly_sel_i = p;
    @(negedge clk);
    start_i = 1'b0; state_i = ~s;
    check("R4 valid low in busy cycle", {31'b0, valid_o}, 32'd0);
    @(negedge clk);
    check("R4 valid pulse", {31'b0, valid_o}, 32'd1);
    check(tag, result_o, ref_crc(s, w, p));
  endtask

  task automatic t_reset;
    check("R7 valid in reset", {31'b0, valid_o}, 32'd0);
    check("R7 result in reset", result_o, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 valid after reset", {31'b0, valid_o}, 32'd0);
    check("R7 result after reset", result_o, 32'd0);
  endtask

  task automatic t_sweep;
    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < 3; w++) begin
        for (int k = 0; k < 4; k++) begin
          run_one($urandom, 2'(w), p[0], p == 0 ? "R1 crc32 random" : "R2 crc32c random");
        end
      end
    end
  endtask

  task automatic t_corners;
    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < 3; w++) begin
        run_one(32'h0, 2'(w), p[0], "R8 zero state");
        run_one(32'hFFFFFFFF, 2'(w), p[0], "R8 ones state");
      end
      run_one(32'h12345678, 2'b11, p[0], "R3 code 11 is word");
      run_one(32'hFFFFFFFF, 2'b11, p[0], "R3 code 11 ones");
    end
  endtask

  task automatic t_busy_ignore;
    logic [31:0] a;
    a = 32'hC0FFEE11;
    @(negedge clk);
    start_i = 1'b1; state_i = a; width_i = 2'b01; poly_sel_i = 1'b0;
    @(negedge clk);
    state_i = 32'h5A5A5A5A; width_i = 2'b10; poly_sel_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R5 first result kept", result_o, ref_crc(a, 2'b01, 1'b0));
    @(negedge clk);
    check("R5 no pulse for dropped start", {31'b0, valid_o}, 32'd0);
    @(negedge clk);
    check("R5 no late pulse", {31'b0, valid_o}, 32'd0);
    check("R6 result held", result_o, ref_crc(a, 2'b01, 1'b0));
  endtask

  task automatic t_hold;
    logic [31:0] e;
    run_one(32'h0BADF00D, 2'b00, 1'b1, "R2 byte before hold");
    e = ref_crc(32'h0BADF00D, 2'b00, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      state_i = $urandom; width_i = 2'(i); poly_sel_i = ~poly_sel_i;
    end
    check("R6 held across idle inputs", result_o, e);
    check("R6 valid idle", {31'b0, valid_o}, 32'd0);
  endtask

  task automatic t_back_to_back;
    logic [31:0] s [4];
    for (int i = 0; i < 4; i++) s[i] = $urandom;
    @(negedge clk);
    start_i = 1'b1; width_i = 2'b10; poly_sel_i = 1'b1;
    state_i = s[0];
    @(negedge clk);
    state_i = s[1];
    @(negedge clk);
    check("R9 first pulse", {31'b0, valid_o}, 32'd1);
    check("R9 first result", result_o, ref_crc(s[0], 2'b10, 1'b1));
    state_i = s[2];
    @(negedge clk);
    check("R9 gap", {31'b0, valid_o}, 32'd0);
    state_i = s[3];
    @(negedge clk);
    start_i = 1'b0;
    check("R9 second pulse", {31'b0, valid_o}, 32'd1);
    check("R9 second result", result_o, ref_crc(s[2], 2'b10, 1'b1));
    @(negedge clk);
    @(negedge clk);
    check("R9 odd starts dropped", {31'b0, valid_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_sweep();
    t_corners();
    t_busy_ignore();
    t_hold();
    t_back_to_back();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule